// File: doc/BRIEF.md
# SPI Register and Status Front End

This block is the bus-facing register bank of a serial peripheral interface controller. Software reaches it through byte offsets. It holds a control word, a clock divider value, a transmit holding byte and a receive holding byte. The block also keeps a set of status flags. These flags set themselves on transmit and receive events and clear themselves as a side effect of software reading the receive byte or writing the transmit byte.

A separate shift engine does the serial work and talks to the block through three strobes:
- a pulse that takes the next byte to send,
- a pulse that hands over a received byte,
- a pulse from this block that starts a transfer.

The block applies the overflow and underflow policies chosen in the control word. It decides whether software starts a transfer by writing the transmit byte or by reading the receive byte. It drives one interrupt line. The same control bit that picks the trigger also picks which side (transmit or receive) feeds that interrupt.

Top module: `spi_regfront`

## Requirements
- R1: Each register sits at a fixed byte offset. Status is at 0x00 (read only). Receive byte is at 0x04 (read only). Transmit byte is at 0x08 (write only, reads 0). Divider is at 0x0C (read/write). Control is at 0x10 (read/write). In the control word, only bits 12:5 and 3:0 are writable; bits 15:13 and bit 4 read 0. Writes to the read-only offsets are ignored, and reads outside a bus read cycle return 0.
- R2: After reset, control reads 0x0000, divider reads 0x1B, status reads 0x00 and the receive byte reads 0x00. The interrupt and start outputs are low.
- R3: Status bit positions are: bit 0 transmit full, bit 1 transmit interrupt, bit 2 transmit underflow, bit 3 receive full, bit 4 receive interrupt, bit 5 receive overflow. Bits 7:6 always read 0.
- R4: While enabled, a transmit write stores the byte, sets bit 0 and clears bits 2 and 1 from the next cycle. A take strobe while bit 0 is set hands that byte to the engine and clears bit 0 from the next cycle.
- R5: A take strobe while bit 0 is clear sets bit 2. The byte offered to the engine is then 0x00 when control bit 7 is 1, or the last written transmit byte when it is 0.
- R6: Status bit 1 is 1 exactly when the block is enabled and either bit 0 is clear or bit 2 is set.
- R7: While enabled, a received byte arriving with bit 3 clear is stored and sets bit 3. A read of the receive byte returns it and clears bits 3, 4 and 5 from the next cycle. If a byte arrives in the same cycle as that read, the read is applied first.
- R8: A byte arriving while bit 3 is set sets bit 5. With control bit 8 at 1 the new byte replaces the stored one; with bit 8 at 0 it is dropped.
- R9: Status bit 4 is 1 exactly when bit 3 or bit 5 is 1.
- R10: The start output gives one pulse in the cycle after the trigger access. The trigger is a transmit write when control bit 6 is 1, or a receive read when it is 0. It fires only while control bit 0 (enable) and bit 1 (master) are both 1.
- R11: The interrupt output follows status bit 1 when control bit 6 is 1, and status bit 4 when it is 0.
- R12: While control bit 0 is 0, all status flags read 0. Transmit writes, take strobes and received bytes change no flag and no stored byte. Clearing bit 0 returns the flags to 0 at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in a read cycle |
| eng_take | input | 1 | Engine takes the next transmit byte |
| eng_tx_byte | output | 8 | Byte offered to the engine |
| eng_rx_valid | input | 1 | Engine delivers a received byte |
| eng_rx_byte | input | 8 | Received byte |
| eng_start | output | 1 | Transfer start pulse to the engine |
| cfg_ctrl | output | 16 | Current control word |
| cfg_div | output | 8 | Current divider value |
| irq | output | 1 | Interrupt request |

## Verification
The properties assume a single bus master. At most one register access happens per cycle, so a control write never falls in the same cycle as a transmit write or a receive read, and the enable bit cannot change under those events. The bench drives one access per step through its task layer, which enforces this by construction. It is still free to put take and receive strobes in the same cycle as any access, and it does so for the read-and-arrive corner.

// File: rtl/spi_regfront_pkg.sv
package spi_regfront_pkg;

  localparam int unsigned OFF_STA = 0;
  localparam int unsigned OFF_RX  = 4;
  localparam int unsigned OFF_TX  = 8;
  localparam int unsigned OFF_DIV = 12;
  localparam int unsigned OFF_CON = 16;

  localparam int unsigned CB_EN     = 0;
  localparam int unsigned CB_MST    = 1;
  localparam int unsigned CB_TXTRIG = 6;
  localparam int unsigned CB_UFZERO = 7;
  localparam int unsigned CB_OVWR   = 8;

  localparam logic [15:0] CON_WMASK = 16'h1FEF;

  // ordered so that the packed value lands on status bits 5..0
  typedef struct packed {
    logic rx_ovf;
    logic rx_irq;
    logic rx_full;
    logic tx_uf;
    logic tx_irq;
    logic tx_full;
  } flags_t;

endpackage

// File: rtl/spi_rst_sync.sv
module spi_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/spi_bus_decode.sv
module spi_bus_decode
  import spi_regfront_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CTRL_W = 16
) (
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] sta,
  input  logic [DATA_W-1:0] rx_data,
  input  logic [DATA_W-1:0] div,
  input  logic [CTRL_W-1:0] con,
  output logic              wr_tx,
  output logic              wr_div,
  output logic              wr_con,
  output logic              rd_rx,
  output logic [CTRL_W-1:0] rdata
);
  logic hit_sta, hit_rx, hit_tx, hit_div, hit_con;
  logic is_rd, is_wr;

  assign hit_sta = (addr == ADDR_W'(OFF_STA));
  assign hit_rx  = (addr == ADDR_W'(OFF_RX));
  assign hit_tx  = (addr == ADDR_W'(OFF_TX));
  assign hit_div = (addr == ADDR_W'(OFF_DIV));
  assign hit_con = (addr == ADDR_W'(OFF_CON));

  assign is_rd = sel & ~wr;
  assign is_wr = sel & wr;

  assign wr_tx  = is_wr & hit_tx;
  assign wr_div = is_wr & hit_div;
  assign wr_con = is_wr & hit_con;
  assign rd_rx  = is_rd & hit_rx;

  always_comb begin
    rdata = '0;
    if (is_rd) begin
      if (hit_sta) rdata = CTRL_W'(sta);
      if (hit_rx)  rdata = CTRL_W'(rx_data);
      if (hit_div) rdata = CTRL_W'(div);
      if (hit_con) rdata = con;
    end
  end
endmodule

// File: rtl/spi_tx_path.sv
module spi_tx_path #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              srst_n,
  input  logic              en_q,
  input  logic              en_n,
  input  logic              uf_zero,
  input  logic              wr_tx,
  input  logic [DATA_W-1:0] wdata,
  input  logic              take,
  output logic [DATA_W-1:0] tx_byte,
  output logic              tx_full,
  output logic              tx_uf,
  output logic              tx_irq
);
  logic [DATA_W-1:0] data_q;
  logic              full_q, full_n;
  logic              uf_q, uf_n;
  logic              irq_q, irq_n;
  logic              load_en;

  assign load_en = en_q & wr_tx;

  always_comb begin
    full_n = full_q;
    uf_n   = uf_q;
    if (en_q && take) begin
      if (full_q) full_n = 1'b0;
      else        uf_n   = 1'b1;
    end
    if (load_en) begin
      full_n = 1'b1;
      uf_n   = 1'b0;
    end
    if (!en_n) begin
      full_n = 1'b0;
      uf_n   = 1'b0;
    end
    irq_n = en_n & (~full_n | uf_n);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      full_q <= 1'b0;
      uf_q   <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      full_q <= full_n;
      uf_q   <= uf_n;
      irq_q  <= irq_n;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)      data_q <= '0;
    else if (load_en) data_q <= wdata;
  end

  assign tx_byte = (full_q || !uf_zero) ? data_q : '0;
  assign tx_full = full_q;
  assign tx_uf   = uf_q;
  assign tx_irq  = irq_q;
endmodule

// File: rtl/spi_rx_path.sv
module spi_rx_path #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              srst_n,
  input  logic              en_q,
  input  logic              en_n,
  input  logic              ovwr,
  input  logic              rd_rx,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_byte,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  output logic              rx_ovf,
  output logic              rx_irq
);
  logic [DATA_W-1:0] data_q;
  logic              full_q, full_n;
  logic              ovf_q, ovf_n;
  logic              irq_q, irq_n;
  logic              store_en;

  always_comb begin
    full_n   = full_q;
    ovf_n    = ovf_q;
    store_en = 1'b0;
    if (rd_rx) begin
      full_n = 1'b0;
      ovf_n  = 1'b0;
    end
    if (en_q && rx_valid) begin
      if (!full_n) begin
        store_en = 1'b1;
        full_n   = 1'b1;
      end else begin
        ovf_n    = 1'b1;
        store_en = ovwr;
      end
    end
    if (!en_n) begin
      full_n = 1'b0;
      ovf_n  = 1'b0;
    end
    irq_n = en_n & (full_n | ovf_n);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      full_q <= 1'b0;
      ovf_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      full_q <= full_n;
      ovf_q  <= ovf_n;
      irq_q  <= irq_n;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)       data_q <= '0;
    else if (store_en) data_q <= rx_byte;
  end

  assign rx_data = data_q;
  assign rx_full = full_q;
  assign rx_ovf  = ovf_q;
  assign rx_irq  = irq_q;
endmodule

// File: rtl/spi_regfront.sv
module spi_regfront
  import spi_regfront_pkg::*;
#(
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CTRL_W    = 16,
  parameter int unsigned DIV_RESET = 27,
  parameter int unsigned SYNC_STG  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CTRL_W-1:0] bus_wdata,
  output logic [CTRL_W-1:0] bus_rdata,
  input  logic              eng_take,
  output logic [DATA_W-1:0] eng_tx_byte,
  input  logic              eng_rx_valid,
  input  logic [DATA_W-1:0] eng_rx_byte,
  output logic              eng_start,
  output logic [CTRL_W-1:0] cfg_ctrl,
  output logic [DATA_W-1:0] cfg_div,
  output logic              irq
);
  localparam logic [CTRL_W-1:0] WMASK   = CTRL_W'(CON_WMASK);
  localparam logic [DATA_W-1:0] DIV_RST = DATA_W'(DIV_RESET);
  localparam int unsigned       PAD_W   = DATA_W - $bits(flags_t);

  logic              srst_n;
  logic [CTRL_W-1:0] con_q, con_n;
  logic [DATA_W-1:0] div_q;
  logic              start_q, start_n;
  logic              wr_tx, wr_div, wr_con, rd_rx;
  logic              en_q, en_n, mst_q, trig_tx_q;
  logic [DATA_W-1:0] rx_data;
  logic [DATA_W-1:0] sta;
  flags_t            flg;

  spi_rst_sync #(.STAGES(SYNC_STG)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  spi_bus_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_W(CTRL_W)) u_dec (
    .sel     (bus_sel),
    .wr      (bus_wr),
    .addr    (bus_addr),
    .sta     (sta),
    .rx_data (rx_data),
    .div     (div_q),
    .con     (con_q),
    .wr_tx   (wr_tx),
    .wr_div  (wr_div),
    .wr_con  (wr_con),
    .rd_rx   (rd_rx),
    .rdata   (bus_rdata)
  );

  always_comb begin
    con_n = con_q;
    if (wr_con) con_n = bus_wdata & WMASK;
  end

  assign en_q      = con_q[CB_EN];
  assign en_n      = con_n[CB_EN];
  assign mst_q     = con_q[CB_MST];
  assign trig_tx_q = con_q[CB_TXTRIG];

  always_comb begin
    start_n = en_q & mst_q & (trig_tx_q ? wr_tx : rd_rx);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      con_q   <= '0;
      start_q <= 1'b0;
    end else begin
      con_q   <= con_n;
      start_q <= start_n;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)     div_q <= DIV_RST;
    else if (wr_div) div_q <= bus_wdata[DATA_W-1:0];
  end

  spi_tx_path #(.DATA_W(DATA_W)) u_tx (
    .clk     (clk),
    .srst_n  (srst_n),
    .en_q    (en_q),
    .en_n    (en_n),
    .uf_zero (con_q[CB_UFZERO]),
    .wr_tx   (wr_tx),
    .wdata   (bus_wdata[DATA_W-1:0]),
    .take    (eng_take),
    .tx_byte (eng_tx_byte),
    .tx_full (flg.tx_full),
    .tx_uf   (flg.tx_uf),
    .tx_irq  (flg.tx_irq)
  );

  spi_rx_path #(.DATA_W(DATA_W)) u_rx (
    .clk      (clk),
    .srst_n   (srst_n),
    .en_q     (en_q),
    .en_n     (en_n),
    .ovwr     (con_q[CB_OVWR]),
    .rd_rx    (rd_rx),
    .rx_valid (eng_rx_valid),
    .rx_byte  (eng_rx_byte),
    .rx_data  (rx_data),
    .rx_full  (flg.rx_full),
    .rx_ovf   (flg.rx_ovf),
    .rx_irq   (flg.rx_irq)
  );

  assign sta       = {{PAD_W{1'b0}}, flg};
  assign irq       = trig_tx_q ? flg.tx_irq : flg.rx_irq;
  assign eng_start = start_q;
  assign cfg_ctrl  = con_q;
  assign cfg_div   = div_q;
endmodule

// File: rtl/spi_regfront_chk.sv
module spi_regfront_chk (
  input logic       clk,
  input logic       srst_n,
  input logic       en,
  input logic       master,
  input logic       wr_tx,
  input logic       wr_con,
  input logic       rd_rx,
  input logic       rx_valid,
  input logic [7:0] sta,
  input logic       eng_start,
  input logic       irq
);
  p_sta_resv_r3: assert property (@(posedge clk) disable iff (!srst_n)
    sta[7:6] == 2'b00);

  p_txwr_r4: assert property (@(posedge clk) disable iff (!srst_n)
    (en && wr_tx) |=> (sta[0] && !sta[2] && !sta[1]));

  p_rdclr_r7: assert property (@(posedge clk) disable iff (!srst_n)
    (rd_rx && !(en && rx_valid)) |=> (sta[5:3] == 3'b000));

  p_ovf_r8: assert property (@(posedge clk) disable iff (!srst_n)
    (en && sta[3] && rx_valid && !rd_rx && !wr_con) |=> sta[5]);

  p_rxirq_r9: assert property (@(posedge clk) disable iff (!srst_n)
    (en && rx_valid && !wr_con) |=> sta[4]);

  p_start_r10: assert property (@(posedge clk) disable iff (!srst_n)
    eng_start |-> $past(en && master));

  p_irq_src_r11: assert property (@(posedge clk) disable iff (!srst_n)
    irq |-> (sta[1] || sta[4]));

  p_off_r12: assert property (@(posedge clk) disable iff (!srst_n)
    !en |-> (sta == 8'h00));
endmodule

bind spi_regfront spi_regfront_chk u_chk (
  .clk       (clk),
  .srst_n    (srst_n),
  .en        (en_q),
  .master    (mst_q),
  .wr_tx     (wr_tx),
  .wr_con    (wr_con),
  .rd_rx     (rd_rx),
  .rx_valid  (eng_rx_valid),
  .sta       (sta),
  .eng_start (eng_start),
  .irq       (irq)
);

// File: tb/spi_regfront_tb.sv
module spi_regfront_tb;
  logic        clk;
  logic        rst_n;
  logic        b_sel, b_wr;
  logic [4:0]  b_addr;
  logic [15:0] b_wdata;
  logic [15:0] rdata;
  logic        e_take, e_rxv;
  logic [7:0]  e_rxb;
  logic [7:0]  tx_byte;
  logic        start;
  logic [15:0] ctrl;
  logic [7:0]  div;
  logic        irq;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  // reference state
  logic [15:0] m_con;
  logic [7:0]  m_div, m_txd, m_rxd;
  bit          m_txf, m_txu, m_rxf, m_rxo, m_start;

  spi_regfront u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_sel      (b_sel),
    .bus_wr       (b_wr),
    .bus_addr     (b_addr),
    .bus_wdata    (b_wdata),
    .bus_rdata    (rdata),
    .eng_take     (e_take),
    .eng_tx_byte  (tx_byte),
    .eng_rx_valid (e_rxv),
    .eng_rx_byte  (e_rxb),
    .eng_start    (start),
    .cfg_ctrl     (ctrl),
    .cfg_div      (div),
    .irq          (irq)
  );

  initial clk = 1'b0;
  always #10ns clk = ~clk;

  function automatic bit f_txirq();
    return m_con[0] && (!m_txf || m_txu);
  endfunction

  function automatic bit f_rxirq();
    return m_con[0] && (m_rxf || m_rxo);
  endfunction

  function automatic logic [7:0] f_sta();
    return {2'b00, m_rxo, f_rxirq(), m_rxf, m_txu, f_txirq(), m_txf};
  endfunction

  function automatic logic [15:0] f_rdata();
    if (!b_sel || b_wr) return 16'h0;
    case (b_addr)
      5'h00:   return {8'h00, f_sta()};
      5'h04:   return {8'h00, m_rxd};
      5'h0C:   return {8'h00, m_div};
      5'h10:   return m_con;
      default: return 16'h0;
    endcase
  endfunction

  task automatic chk(string ph, string sig, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", ph, sig, act, exp);
    end
  endtask

  task automatic compare(string ph);
    chk(ph, "rdata",   rdata, f_rdata());
    chk(ph, "tx_byte", {8'h00, tx_byte}, {8'h00, (m_txf || !m_con[7]) ? m_txd : 8'h00});
    chk(ph, "start",   {15'h0, start}, {15'h0, m_start});
    chk(ph, "irq",     {15'h0, irq}, {15'h0, m_con[6] ? f_txirq() : f_rxirq()});
    chk(ph, "ctrl",    ctrl, m_con);
    chk(ph, "div",     {8'h00, div}, {8'h00, m_div});
  endtask

  task automatic model_update();
    bit rd_rx, wr_tx, en;
    rd_rx = b_sel && !b_wr && b_addr == 5'h04;
    wr_tx = b_sel && b_wr && b_addr == 5'h08;
    en    = m_con[0];
    m_start = en && m_con[1] && (m_con[6] ? wr_tx : rd_rx);
    if (en && e_take) begin
      if (m_txf) m_txf = 0;
      else       m_txu = 1;
    end
    if (en && wr_tx) begin
      m_txd = b_wdata[7:0];
      m_txf = 1;
      m_txu = 0;
    end
    if (rd_rx) begin
      m_rxf = 0;
      m_rxo = 0;
    end
    if (en && e_rxv) begin
      if (!m_rxf) begin
        m_rxd = e_rxb;
        m_rxf = 1;
      end else begin
        m_rxo = 1;
        if (m_con[8]) m_rxd = e_rxb;
      end
    end
    if (b_sel && b_wr && b_addr == 5'h10) m_con = b_wdata & 16'h1FEF;
    if (b_sel && b_wr && b_addr == 5'h0C) m_div = b_wdata[7:0];
    if (!m_con[0]) begin
      m_txf = 0; m_txu = 0; m_rxf = 0; m_rxo = 0;
    end
  endtask

  task automatic step(string ph);
    #2ns;
    compare(ph);
    @(posedge clk);
    model_update();
    @(negedge clk);
    b_sel = 0; b_wr = 0; b_addr = '0; b_wdata = '0;
    e_take = 0; e_rxv = 0; e_rxb = '0;
  endtask

  task automatic wr(logic [4:0] a, logic [15:0] d, string ph);
    b_sel = 1; b_wr = 1; b_addr = a; b_wdata = d;
    step(ph);
  endtask

  task automatic rd(logic [4:0] a, string ph);
    b_sel = 1; b_wr = 0; b_addr = a;
    step(ph);
  endtask

  task automatic take(string ph);
    e_take = 1;
    step(ph);
  endtask

  task automatic rxin(logic [7:0] v, string ph);
    e_rxv = 1; e_rxb = v;
    step(ph);
  endtask

  task automatic idle(int n, string ph);
    for (int i = 0; i < n; i++) step(ph);
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    m_con = 16'h0; m_div = 8'h1B; m_txd = 8'h0; m_rxd = 8'h0;
    m_txf = 0; m_txu = 0; m_rxf = 0; m_rxo = 0; m_start = 0;
    b_sel = 0; b_wr = 0; b_addr = '0; b_wdata = '0;
    e_take = 0; e_rxv = 0; e_rxb = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(3, "R2");
    // R2 reset contents
    rd(5'h00, "R2"); rd(5'h04, "R2"); rd(5'h0C, "R2"); rd(5'h10, "R2");

    // R1 access rules and reserved bits
    wr(5'h10, 16'hFFFE, "R1"); rd(5'h10, "R1");
    wr(5'h10, 16'h0000, "R1");
    wr(5'h0C, 16'h0007, "R1"); rd(5'h0C, "R1");
    wr(5'h04, 16'h00EE, "R1"); wr(5'h00, 16'h00FF, "R1");
    rd(5'h04, "R1"); rd(5'h00, "R1"); rd(5'h08, "R1"); rd(5'h14, "R1");

    // R12 disabled: nothing moves
    wr(5'h08, 16'h0055, "R12"); take("R12"); rxin(8'h77, "R12");
    rd(5'h00, "R12"); rd(5'h04, "R12");

    // master, transmit-triggered
    wr(5'h10, 16'h0043, "R6"); idle(2, "R6"); rd(5'h00, "R11");
    wr(5'h08, 16'h00A5, "R10"); rd(5'h00, "R4"); rd(5'h00, "R3");
    take("R4"); rd(5'h00, "R6");
    take("R5"); rd(5'h00, "R5");
    wr(5'h08, 16'h003C, "R4"); rd(5'h00, "R4");
    wr(5'h10, 16'h00C3, "R5"); take("R5"); take("R5"); rd(5'h00, "R5");
    e_take = 1; wr(5'h08, 16'h0011, "R4"); rd(5'h00, "R4");

    // master, receive-triggered, discard on overflow
    wr(5'h10, 16'h0003, "R7"); rd(5'h00, "R11");
    rxin(8'h3C, "R7"); rd(5'h00, "R9");
    rxin(8'h99, "R8"); rd(5'h00, "R8");
    rd(5'h04, "R10"); rd(5'h00, "R7");
    // overwrite on overflow
    wr(5'h10, 16'h0103, "R8"); rxin(8'h12, "R8"); rxin(8'h34, "R8");
    rd(5'h00, "R9"); rd(5'h04, "R8");
    // read and arrival in the same cycle
    rxin(8'h56, "R7"); e_rxv = 1; e_rxb = 8'h78; rd(5'h04, "R7");
    rd(5'h00, "R7"); rd(5'h04, "R7");

    // slave: no start pulses
    wr(5'h10, 16'h0041, "R10"); wr(5'h08, 16'h0022, "R10"); idle(2, "R10");
    wr(5'h10, 16'h0001, "R10"); rd(5'h04, "R10"); idle(1, "R10");

    // R12 disable with flags set
    wr(5'h10, 16'h0103, "R12"); rxin(8'hC3, "R12"); rxin(8'hC4, "R12");
    wr(5'h10, 16'h0102, "R12"); rd(5'h00, "R12"); rd(5'h04, "R12"); idle(2, "R12");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule